// File: doc/BRIEF.md
# DRAM Compressed Parallel Test Mode

This block is the device-side control and data logic for the compressed test mode of a four-bit-wide DRAM. It samples the active-low row strobe, column strobe and write enable on a fast clock and orders their edges to sort each RAS cycle into one of these kinds: a test-entry cycle, a refresh with the column strobe first, a row access, or a row-only refresh. A small register-file array stands in for the storage cells so the whole path can be exercised.

In normal mode a column access reads or writes one four-bit word. In test mode the two lowest column address bits are ignored. A write copies each data bit into all four words of the addressed group. A read returns one flag per data pin: high when that bit is the same in all four words, low when it differs. Test mode is entered with a cycle where WE and CAS are both low before RAS falls. It is left by a refresh where CAS falls first with WE high, or by a RAS cycle that has no column access.

Top module: `dram_test_mode`

## Requirements
- R1: After reset, test_mode_o is 0, dq_oe_o is 0 and every array word is 0.
- R2: A RAS fall sampled while CAS and WE are both already low sets test_mode_o to 1 from the next cycle.
- R3: In normal mode, a CAS fall while RAS is low after a row access with WE high drives dq_o with the word at {row, column} and sets dq_oe_o from the next cycle. Later CAS falls in the same RAS cycle update dq_o (page mode). dq_oe_o returns to 0 the cycle after RAS rises.
- R4: In test mode, a write ignores column bits [1:0] and stores dq_i into all four words of the group {row, column[COL_W-1:2]}. In normal mode a write stores only the addressed word.
- R5: In test mode, a read ignores column bits [1:0]. dq_o bit b is 1 when bit b is equal in all four words of the group and 0 otherwise.
- R6: A RAS fall sampled while CAS is low and WE is high (refresh with the column strobe first) clears test_mode_o from the next cycle.
- R7: A RAS low period that ends without a CAS fall after its row access (a row-only refresh) clears test_mode_o in the cycle after RAS rises.
- R8: In test mode, read cycles and repeated test-entry cycles leave test_mode_o at 1. test_mode_o rises only after a test-entry cycle.
- R9: dq_oe_o is 0 during test-entry cycles, refreshes with the column strobe first, and row-only refreshes.
- R10: A CAS fall with WE low (early write) leaves dq_oe_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, much faster than the strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W (4) | Multiplexed row/column address |
| dq_i | input | DQ_W (4) | Write data |
| dq_o | output | DQ_W (4) | Read data, or per-pin equality flags in test mode |
| dq_oe_o | output | 1 | Output enable for dq_o; 0 means high impedance |
| test_mode_o | output | 1 | 1 while compressed test mode is active |

## Verification
The bench uses the default parameters: 16 rows, 16 columns, four data bits. With these values each row has four four-word compare groups, and a bench array model can cover the whole store. Random writes and reads across rows and groups reach partly equal groups as well as fully equal ones. Ordered strobe sequences then cover every way in and out of test mode, and page-mode reads cross the edges of test mode.

// File: rtl/dram_tm_pkg.sv
package dram_tm_pkg;
  // one-cycle events decoded from strobe ordering
  typedef struct packed {
    logic set_mode;  // WE and CAS low before RAS fall
    logic cbr_ref;   // CAS low, WE high before RAS fall
    logic row_act;   // RAS fall with CAS high
    logic ras_only;  // RAS rise after row access with no column access
    logic ras_rise;
    logic col_rd;
    logic col_wr;
  } strobe_ev_t;
endpackage

// File: rtl/tm_strobe_decode.sv
module tm_strobe_decode
  import dram_tm_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [ROW_W-1:0] row_i,
  output strobe_ev_t       ev_o,
  output logic [ROW_W-1:0] row_o
);
  logic ras_q, cas_q, row_open_q, col_seen_q;
  logic [ROW_W-1:0] row_q;
  logic ras_fall, ras_rise, cas_fall, col_ev;

  assign ras_fall = ras_q & ~ras_ni;
  assign ras_rise = ~ras_q & ras_ni;
  assign cas_fall = cas_q & ~cas_ni;
  assign col_ev   = cas_fall & ~ras_ni & row_open_q;

  always_comb begin
    ev_o.set_mode = ras_fall & ~cas_ni & ~we_ni;
    ev_o.cbr_ref  = ras_fall & ~cas_ni & we_ni;
    ev_o.row_act  = ras_fall & cas_ni;
    ev_o.ras_only = ras_rise & row_open_q & ~col_seen_q;
    ev_o.ras_rise = ras_rise;
    ev_o.col_rd   = col_ev & we_ni;
    ev_o.col_wr   = col_ev & ~we_ni;
  end

  assign row_o = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      row_open_q <= 1'b0;
      col_seen_q <= 1'b0;
      row_q      <= '0;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      if (ras_fall && cas_ni) begin
        row_open_q <= 1'b1;
        col_seen_q <= 1'b0;
        row_q      <= row_i;
      end else if (ras_rise) begin
        row_open_q <= 1'b0;
      end
      if (col_ev) col_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tm_mode_ctl.sv
module tm_mode_ctl
  import dram_tm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  strobe_ev_t ev_i,
  output logic       test_mode_o
);
  logic tm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           tm_q <= 1'b0;
    else if (ev_i.set_mode)                tm_q <= 1'b1;
    else if (ev_i.cbr_ref || ev_i.ras_only) tm_q <= 1'b0;
  end

  assign test_mode_o = tm_q;
endmodule

// File: rtl/tm_cell_array.sv
module tm_cell_array #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DQ_W  = 4,
  parameter int GRP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             test_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DQ_W-1:0]  data_i,
  output logic [DQ_W-1:0]  rd_o
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int GRP   = 1 << GRP_W;

  logic [DQ_W-1:0] mem [DEPTH];
  logic [DQ_W-1:0] grp_w [GRP];
  logic [DQ_W-1:0] eq;
  logic [COL_W-GRP_W-1:0] col_hi;

  assign col_hi = col_i[COL_W-1:GRP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < GRP; k++)
        if (test_i || col_i[GRP_W-1:0] == k[GRP_W-1:0])
          mem[{row_i, col_hi, k[GRP_W-1:0]}] <= data_i;
    end
  end

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    assign grp_w[g] = mem[{row_i, col_hi, GRP_W'(g)}];
  end

  for (genvar b = 0; b < DQ_W; b++) begin : g_cmp
    always_comb begin
      eq[b] = 1'b1;
      for (int k = 1; k < GRP; k++)
        if (grp_w[k][b] != grp_w[0][b]) eq[b] = 1'b0;
    end
  end

  assign rd_o = test_i ? eq : mem[{row_i, col_i}];
endmodule

// File: rtl/dram_test_mode.sv
module dram_test_mode
  import dram_tm_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DQ_W   = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              test_mode_o
);
  localparam int GRP_W = 2;

  strobe_ev_t       ev;
  logic [ROW_W-1:0] row;
  logic [DQ_W-1:0]  rd_data, rd_q;
  logic             oe_q, tm;

  tm_strobe_decode #(.ROW_W(ROW_W)) i_decode (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .row_i (addr_i[ROW_W-1:0]),
    .ev_o  (ev), .row_o(row)
  );

  tm_mode_ctl i_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev), .test_mode_o(tm)
  );

  tm_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .GRP_W(GRP_W)) i_array (
    .clk_i  (clk_i), .rst_ni(rst_ni),
    .wr_en_i(ev.col_wr), .test_i(tm),
    .row_i  (row), .col_i(addr_i[COL_W-1:0]),
    .data_i (dq_i), .rd_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      oe_q <= 1'b0;
    end else if (ev.col_rd) begin
      rd_q <= rd_data;
      oe_q <= 1'b1;
    end else if (ev.col_wr || ev.ras_rise || ev.set_mode || ev.cbr_ref) begin
      oe_q <= 1'b0;
    end
  end

  assign dq_o        = rd_q;
  assign dq_oe_o     = oe_q;
  assign test_mode_o = tm;
endmodule

// File: rtl/tm_checker.sv
module tm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_ni,
  input logic cas_ni,
  input logic we_ni,
  input logic dq_oe_o,
  input logic test_mode_o
);
  a_r2_set_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && !cas_ni && !we_ni) |=> test_mode_o);

  a_r6_cbr_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && !cas_ni && we_ni) |=> !test_mode_o);

  a_r9_refresh_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && !cas_ni) |=> !dq_oe_o);

  a_r3_release_on_ras_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_ni) |=> !dq_oe_o);

  a_r10_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_ni && $fell(cas_ni) && !we_ni) |=> !dq_oe_o);

  a_r8_entry_only_on_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode_o) |-> $past(!ras_ni && !cas_ni && !we_ni));
endmodule

bind dram_test_mode tm_checker i_tm_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
  .we_ni(we_ni), .dq_oe_o(dq_oe_o), .test_mode_o(test_mode_o)
);

// File: tb/test_dram_test_mode.sv
`timescale 1ns/1ps
module test_dram_test_mode;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [3:0] addr = '0, dq_in = '0;
  logic [3:0] dq_out;
  logic dq_oe, tmode;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] m [256];
  bit tm_m = 0;

  always #2 clk = ~clk;

  dram_test_mode i_dram_test_mode (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe), .test_mode_o(tmode)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_rd(int r, int c);
    logic [3:0] e;
    int base;
    if (!tm_m) return m[r*16 + c];
    base = r*16 + (c & 12);
    for (int b = 0; b < 4; b++) begin
      e[b] = 1'b1;
      for (int k = 1; k < 4; k++)
        if (m[base+k][b] != m[base][b]) e[b] = 1'b0;
    end
    return e;
  endfunction

  task automatic cyc(logic r, logic c, logic w, logic [3:0] a, logic [3:0] d);
    ras_n = r; cas_n = c; we_n = w; addr = a; dq_in = d;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1, 1, 1, 0, 0);
  endtask

  task automatic do_write(int r, int c, logic [3:0] d);
    cyc(0, 1, 1, r[3:0], 0);
    cyc(0, 0, 0, c[3:0], d);
    chk("R10 write keeps hi-z", {7'd0, dq_oe}, 8'd0);
    cyc(0, 1, 1, c[3:0], d);
    cyc(1, 1, 1, 0, 0);
    idle();
    if (tm_m) for (int k = 0; k < 4; k++) m[r*16 + (c & 12) + k] = d;
    else m[r*16 + c] = d;
  endtask

  task automatic do_read(int r, int c, string req);
    cyc(0, 1, 1, r[3:0], 0);
    cyc(0, 0, 1, c[3:0], 0);
    chk(req, {3'd0, dq_oe, dq_out}, {4'd1, exp_rd(r, c)});
    cyc(0, 1, 1, c[3:0], 0);
    cyc(1, 1, 1, 0, 0);
    chk("R3 oe released after RAS rise", {7'd0, dq_oe}, 8'd0);
    idle();
  endtask

  task automatic do_set();
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R2 set enters test mode", {7'd0, tmode}, 8'd1);
    chk("R9 hi-z during set", {7'd0, dq_oe}, 8'd0);
    cyc(1, 0, 0, 0, 0);
    idle();
    idle();
    tm_m = 1;
  endtask

  task automatic do_cbr();
    cyc(1, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R6 CBR exits test mode", {7'd0, tmode}, 8'd0);
    chk("R9 hi-z during CBR", {7'd0, dq_oe}, 8'd0);
    cyc(1, 0, 1, 0, 0);
    idle();
    idle();
    tm_m = 0;
  endtask

  task automatic do_ras_only(int r);
    cyc(0, 1, 1, r[3:0], 0);
    chk("R9 hi-z during RAS-only", {7'd0, dq_oe}, 8'd0);
    cyc(0, 1, 1, r[3:0], 0);
    cyc(1, 1, 1, 0, 0);
    chk("R7 RAS-only exits test mode", {7'd0, tmode}, 8'd0);
    idle();
    tm_m = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", {7'd0, tmode}, 8'd0);
    chk("R1 reset oe", {7'd0, dq_oe}, 8'd0);
    do_read(3, 7, "R1 array clear after reset");

    // normal write/read, single word only
    do_write(2, 5, 4'hA);
    do_read(2, 5, "R3 normal read");
    do_read(2, 4, "R4 normal write touches one word");
    do_read(2, 6, "R4 normal write touches one word");

    // page mode: two column accesses in one RAS
    do_write(9, 0, 4'h3);
    do_write(9, 1, 4'hC);
    cyc(0, 1, 1, 4'd9, 0);
    cyc(0, 0, 1, 4'd0, 0);
    chk("R3 page read first", {3'd0, dq_oe, dq_out}, {4'd1, 4'h3});
    cyc(0, 1, 1, 4'd0, 0);
    chk("R3 oe held between CAS", {7'd0, dq_oe}, 8'd1);
    cyc(0, 0, 1, 4'd1, 0);
    chk("R3 page read second", {3'd0, dq_oe, dq_out}, {4'd1, 4'hC});
    cyc(0, 1, 1, 4'd1, 0);
    cyc(1, 1, 1, 0, 0);
    chk("R3 oe released", {7'd0, dq_oe}, 8'd0);
    idle();

    // mismatched group: words 0x3,0x5,0x3,0x3 -> flags 4'b1001
    do_write(4, 8, 4'h3);
    do_write(4, 9, 4'h5);
    do_write(4, 10, 4'h3);
    do_write(4, 11, 4'h3);
    do_set();
    cyc(0, 1, 1, 4'd4, 0);
    cyc(0, 0, 1, 4'd10, 0);
    chk("R5 partial mismatch flags", {3'd0, dq_oe, dq_out}, {4'd1, 4'b1001});
    cyc(0, 1, 1, 4'd10, 0);
    cyc(1, 1, 1, 0, 0);
    idle();
    chk("R8 read keeps test mode", {7'd0, tmode}, 8'd1);

    // test write fans out, compare passes
    do_write(4, 9, 4'h6);
    do_read(4, 11, "R5 all equal after test write");
    do_set();
    chk("R8 repeated set keeps mode", {7'd0, tmode}, 8'd1);
    do_cbr();
    do_read(4, 8, "R4 test write reaches word 0");
    do_read(4, 10, "R4 test write reaches word 2");
    do_read(4, 12, "R4 other group untouched");

    // exit by RAS-only
    do_set();
    do_read(2, 5, "R5 test read");
    do_ras_only(7);
    do_read(2, 5, "R3 normal read after exit");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, r, c;
      op = $urandom_range(0, 9);
      r = $urandom_range(0, 15);
      c = $urandom_range(0, 15);
      case (op)
        0, 1, 2: do_write(r, c, 4'($urandom_range(0, 15)));
        3, 4, 5, 6: do_read(r, c, tm_m ? "R5 random test read" : "R3 random read");
        7: do_set();
        8: if (tm_m) do_cbr(); else do_set();
        default: do_ras_only(r);
      endcase
      chk("R8 mode tracks model", {7'd0, tmode}, {7'd0, tm_m});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule